// File: doc/BRIEF.md
# Constant-Colour Texture Block Checker

This block inspects one 128-bit compressed texture block per valid strobe and handles the special encoding in which the whole block is a single flat colour. It decides whether such a block is legal, reports that decision on an explicit error output, and hands back the four 16-bit colour channels. A block whose header does not carry the constant-colour tag passes through as "not constant" with no error. Any other block decoder in the pipeline is expected to take over in that case.

Legality covers three things. The two reserved header bits must both be set. The extent rectangle must either be the all-ones "no extent" marker or have each minimum strictly below its maximum. An HDR-flagged block is only legal while HDR decoding is enabled. NaN and infinity channel values are never faults. When the output is bound for an unsigned shared-exponent format, negative HDR channels are clamped to zero. A sticky stream flag records that some legal HDR block carried a negative channel, so the caller can rule out unsigned targets for the whole texture without reading texels.

Top module: `cc_block_check`

## Requirements
- R1: Results appear on the clock edge that samples `inValid` high, so `outValid` is high exactly one cycle after each `inValid` cycle and low otherwise.
- R2: A block is constant-colour when bits [8:0] equal 9'b111111100. Any other block gives `isConst`=0, `errFlag`=0 and all colour outputs zero.
- R3: For a constant-colour block, bits [11:10] must both be 1. Any other value sets `errFlag`.
- R4: Extent fields are sMin [24:12], sMax [37:25], tMin [50:38] and tMax [63:51]. When bits [63:12] are all ones, the extent is accepted. Otherwise `errFlag` is set unless sMin < sMax and tMin < tMax.
- R5: Bit 9 marks an HDR block (1) or an LDR block (0). An HDR block presented while `hdrEn`=0 sets `errFlag`.
- R6: Colour channels come from R [79:64], G [95:80], B [111:96] and A [127:112]. A block with `errFlag` set drives all four colour outputs to zero and never a substitute colour.
- R7: An LDR block outputs its channels unchanged as unsigned normalised values. `sharedExpSel` has no effect on it, and it never sets `negSeen`.
- R8: For a legal HDR block with `sharedExpSel`=1, every channel that is negative is output as 0x0000. A channel is negative when bit 15 is 1 and bits [14:0] are not all zero. Other channels, including 0x8000, pass unchanged. With `sharedExpSel`=0, all channels pass unchanged.
- R9: NaN or infinity channel values (exponent bits [14:10] all ones) in a legal HDR block never set `errFlag`.
- R10: `negSeen` sets when a legal HDR block carries a negative channel, whatever `sharedExpSel` is. It holds until `clearNeg` is sampled high. A set and a clear in the same cycle leave it set.
- R11: While `inValid` is low, `isConst`, `errFlag` and the colour outputs hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Block strobe |
| inBlock | input | 128 | Compressed block |
| hdrEn | input | 1 | HDR decoding enabled |
| sharedExpSel | input | 1 | Output bound for unsigned shared-exponent format |
| clearNeg | input | 1 | Clears the sticky negative flag |
| outValid | output | 1 | Result strobe |
| errFlag | output | 1 | Block is an illegal constant-colour block |
| isConst | output | 1 | Block carries the constant-colour tag |
| colR | output | 16 | Red channel |
| colG | output | 16 | Green channel |
| colB | output | 16 | Blue channel |
| colA | output | 16 | Alpha channel |
| negSeen | output | 1 | Sticky: a legal HDR block had a negative channel |

## Verification
On every cycle, the assertions enforce the one-cycle strobe relation and the reserved-bit error. They also enforce zeroed colour on errors and on untagged blocks, the absence of negative channels after clamping, the stickiness and clearing of the negative flag, and the holding of outputs between strobes. Only the bench scenarios can show the exact channel values. The same is true of the extent comparisons at their equal and reversed edges, of NaN and infinity going through without a fault, of LDR blocks ignoring the clamp, and of a set winning over a simultaneous clear.

// File: rtl/cc_pkg.sv
package cc_pkg;
  // Strobes from the control path to the colour datapath
  typedef struct packed {
    logic load;      // capture a new result
    logic isConst;   // block carries the constant-colour tag
    logic err;       // block is illegal
    logic clampNeg;  // zero negative channels (HDR to shared-exponent)
    logic setNeg;    // legal HDR block with a negative channel
  } ccStrobe_t;

  localparam logic [8:0] CONST_TAG = 9'b111111100;
endpackage

// File: rtl/cc_ctrl.sv
module cc_ctrl
  import cc_pkg::*;
#(
  parameter int HDR_W    = 64,
  parameter int EXT_W    = 13,
  parameter int NUM_COMP = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [HDR_W-1:0]    hdrBits,
  input  logic                hdrEn,
  input  logic                sharedExpSel,
  input  logic [NUM_COMP-1:0] negMask,
  output ccStrobe_t           strobe,
  output logic                outValid,
  output logic                isConst,
  output logic                errFlag
);
  localparam int TAG_W  = 9;
  localparam int HDR_B  = TAG_W;      // HDR/LDR mode bit
  localparam int RSV_LO = TAG_W + 1;  // two reserved bits
  localparam int EXT_LO = RSV_LO + 2;
  localparam int AXES   = 2;
  localparam int EXT_HI = EXT_LO + 2 * AXES * EXT_W - 1;

  logic constHit, hdrBlk, rsvdOk, extOnes, modeOk, extOk, blkErr;
  logic [AXES-1:0] axisOk;

  assign constHit = (hdrBits[TAG_W-1:0] == CONST_TAG);
  assign hdrBlk   = hdrBits[HDR_B];
  assign rsvdOk   = &hdrBits[RSV_LO+1:RSV_LO];
  assign extOnes  = &hdrBits[EXT_HI:EXT_LO];
  assign modeOk   = !hdrBlk || hdrEn;

  genvar a;
  generate
    for (a = 0; a < AXES; a++) begin : g_axis
      logic [EXT_W-1:0] minF, maxF;
      assign minF = hdrBits[EXT_LO + (2*a)   * EXT_W +: EXT_W];
      assign maxF = hdrBits[EXT_LO + (2*a+1) * EXT_W +: EXT_W];
      assign axisOk[a] = (minF < maxF);
    end
  endgenerate

  assign extOk  = extOnes || (&axisOk);
  assign blkErr = constHit && !(rsvdOk && extOk && modeOk);

  always_comb begin
    strobe.load     = inValid;
    strobe.isConst  = constHit;
    strobe.err      = blkErr;
    strobe.clampNeg = constHit && hdrBlk && sharedExpSel;
    strobe.setNeg   = inValid && constHit && hdrBlk && !blkErr && (|negMask);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      isConst  <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        isConst <= constHit;
        errFlag <= blkErr;
      end
    end
  end
endmodule

// File: rtl/cc_datapath.sv
module cc_datapath
  import cc_pkg::*;
#(
  parameter int COMP_W   = 16,
  parameter int NUM_COMP = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_COMP*COMP_W-1:0] colIn,
  input  ccStrobe_t                  strobe,
  input  logic                       clearNeg,
  output logic [NUM_COMP-1:0]        negMask,
  output logic [NUM_COMP*COMP_W-1:0] colOut,
  output logic                       negSeen
);
  localparam int COL_W = NUM_COMP * COMP_W;

  logic [COL_W-1:0] colNext;

  genvar c;
  generate
    for (c = 0; c < NUM_COMP; c++) begin : g_comp
      logic [COMP_W-1:0] chan;
      assign chan       = colIn[c*COMP_W +: COMP_W];
      assign negMask[c] = chan[COMP_W-1] && (|chan[COMP_W-2:0]);
      always_comb begin
        if (!strobe.isConst || strobe.err)
          colNext[c*COMP_W +: COMP_W] = '0;
        else if (strobe.clampNeg && negMask[c])
          colNext[c*COMP_W +: COMP_W] = '0;
        else
          colNext[c*COMP_W +: COMP_W] = chan;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colOut  <= '0;
      negSeen <= 1'b0;
    end else begin
      if (strobe.load) colOut <= colNext;
      negSeen <= (negSeen && !clearNeg) || strobe.setNeg;
    end
  end
endmodule

// File: rtl/cc_block_check.sv
module cc_block_check
  import cc_pkg::*;
#(
  parameter int BLOCK_W  = 128,
  parameter int COMP_W   = 16,
  parameter int NUM_COMP = 4,
  parameter int EXT_W    = 13
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [BLOCK_W-1:0] inBlock,
  input  logic               hdrEn,
  input  logic               sharedExpSel,
  input  logic               clearNeg,
  output logic               outValid,
  output logic               errFlag,
  output logic               isConst,
  output logic [COMP_W-1:0]  colR,
  output logic [COMP_W-1:0]  colG,
  output logic [COMP_W-1:0]  colB,
  output logic [COMP_W-1:0]  colA,
  output logic               negSeen
);
  localparam int COL_W = NUM_COMP * COMP_W;
  localparam int HDR_W = BLOCK_W - COL_W;

  ccStrobe_t           strobe;
  logic [NUM_COMP-1:0] negMask;
  logic [COL_W-1:0]    colOut;

  cc_ctrl #(.HDR_W(HDR_W), .EXT_W(EXT_W), .NUM_COMP(NUM_COMP)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .hdrBits(inBlock[HDR_W-1:0]), .hdrEn(hdrEn), .sharedExpSel(sharedExpSel),
    .negMask(negMask), .strobe(strobe),
    .outValid(outValid), .isConst(isConst), .errFlag(errFlag)
  );

  cc_datapath #(.COMP_W(COMP_W), .NUM_COMP(NUM_COMP)) u_dp (
    .clk(clk), .rstN(rstN), .colIn(inBlock[BLOCK_W-1:HDR_W]),
    .strobe(strobe), .clearNeg(clearNeg),
    .negMask(negMask), .colOut(colOut), .negSeen(negSeen)
  );

  assign colR = colOut[0*COMP_W +: COMP_W];
  assign colG = colOut[1*COMP_W +: COMP_W];
  assign colB = colOut[2*COMP_W +: COMP_W];
  assign colA = colOut[3*COMP_W +: COMP_W];
endmodule

// File: rtl/cc_check.sv
module cc_check #(
  parameter int BLOCK_W = 128,
  parameter int COMP_W  = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic [BLOCK_W-1:0] inBlock,
  input logic               hdrEn,
  input logic               sharedExpSel,
  input logic               clearNeg,
  input logic               outValid,
  input logic               errFlag,
  input logic               isConst,
  input logic [COMP_W-1:0]  colR,
  input logic [COMP_W-1:0]  colG,
  input logic [COMP_W-1:0]  colB,
  input logic [COMP_W-1:0]  colA,
  input logic               negSeen
);
  function automatic logic isNeg(input logic [COMP_W-1:0] v);
    return v[COMP_W-1] && (|v[COMP_W-2:0]);
  endfunction

  p_strobe_follows_r1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_strobe_origin_r1: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid));
  p_untagged_clean_r2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !isConst) |-> (!errFlag && colR == '0 && colG == '0 && colB == '0 && colA == '0));
  p_reserved_bits_r3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inBlock[8:0] == 9'b111111100 && inBlock[11:10] != 2'b11) |=> errFlag);
  p_error_no_colour_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && errFlag) |-> (colR == '0 && colG == '0 && colB == '0 && colA == '0));
  p_clamped_nonneg_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && isConst && !errFlag && $past(hdrEn && sharedExpSel && inBlock[9]))
      |-> !(isNeg(colR) || isNeg(colG) || isNeg(colB) || isNeg(colA)));
  p_neg_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (negSeen && !clearNeg) |=> negSeen);
  p_neg_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (clearNeg && !inValid) |=> !negSeen);
  p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(colR) && $stable(colG) && $stable(colB) && $stable(colA)
                  && $stable(errFlag) && $stable(isConst)));
endmodule

bind cc_block_check cc_check #(.BLOCK_W(BLOCK_W), .COMP_W(COMP_W)) u_check (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inBlock(inBlock), .hdrEn(hdrEn),
  .sharedExpSel(sharedExpSel), .clearNeg(clearNeg), .outValid(outValid),
  .errFlag(errFlag), .isConst(isConst), .colR(colR), .colG(colG), .colB(colB),
  .colA(colA), .negSeen(negSeen)
);

// File: tb/cc_block_check_bench.sv
`timescale 1ns/1ps
module cc_block_check_bench;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [127:0] inBlock = '0;
  logic         hdrEn = 1'b0;
  logic         sharedExpSel = 1'b0;
  logic         clearNeg = 1'b0;
  logic         outValid, errFlag, isConst, negSeen;
  logic [15:0]  colR, colG, colB, colA;

  int nRun = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  cc_block_check u_cc_block_check (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inBlock(inBlock), .hdrEn(hdrEn),
    .sharedExpSel(sharedExpSel), .clearNeg(clearNeg), .outValid(outValid),
    .errFlag(errFlag), .isConst(isConst), .colR(colR), .colG(colG), .colB(colB),
    .colA(colA), .negSeen(negSeen)
  );

  // Extent patterns {tMax, tMin, sMax, sMin}
  localparam logic [51:0] EXT_ONES = 52'hF_FFFF_FFFF_FFFF;
  localparam logic [51:0] EXT_OK   = {13'd1, 13'd0, 13'd1, 13'd0};
  localparam logic [51:0] EXT_SEQ  = {13'd1, 13'd0, 13'd5, 13'd5};
  localparam logic [51:0] EXT_TREV = {13'd2, 13'd9, 13'd1, 13'd0};
  localparam logic [51:0] EXT_NEAR = {13'h1FFE, 13'h1FFF, 13'h1FFF, 13'h1FFF};

  typedef struct packed {
    logic [127:0] blk;
    logic         hdr;
    logic         rgb;
    logic         eErr;
    logic         eConst;
    logic         eNeg;
    logic [63:0]  eCol;   // {A, B, G, R}
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    // R6 R7: legal LDR, channels pass
    '{{64'hDEF0_9ABC_5678_1234, EXT_ONES, 2'b11, 1'b0, 9'h1FC}, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 64'hDEF0_9ABC_5678_1234},
    // R3: reserved 01
    '{{64'hDEF0_9ABC_5678_1234, EXT_ONES, 2'b01, 1'b0, 9'h1FC}, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 64'h0},
    // R3: reserved 10
    '{{64'hDEF0_9ABC_5678_1234, EXT_ONES, 2'b10, 1'b0, 9'h1FC}, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 64'h0},
    // R8 R9 R10: HDR negative, no clamp, Inf
    '{{64'h7C00_8000_3C00_C000, EXT_ONES, 2'b11, 1'b1, 9'h1FC}, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 64'h7C00_8000_3C00_C000},
    // R8: clamp, -0 kept
    '{{64'h7C00_8000_3C00_C000, EXT_ONES, 2'b11, 1'b1, 9'h1FC}, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 64'h7C00_8000_3C00_0000},
    // R8 R9: NaN, negative NaN clamped
    '{{64'h0000_3800_FE00_7E00, EXT_ONES, 2'b11, 1'b1, 9'h1FC}, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 64'h0000_3800_0000_7E00},
    // R8: positive HDR untouched
    '{{64'h3C00_1234_0400_3555, EXT_ONES, 2'b11, 1'b1, 9'h1FC}, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 64'h3C00_1234_0400_3555},
    // R5: HDR block, HDR disabled
    '{{64'h3C00_3C00_3C00_3C00, EXT_ONES, 2'b11, 1'b1, 9'h1FC}, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 64'h0},
    // R7: LDR with sign-looking values, clamp select ignored
    '{{64'hFFFF_8001_8000_FFFF, EXT_ONES, 2'b11, 1'b0, 9'h1FC}, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 64'hFFFF_8001_8000_FFFF},
    // R4: proper extent
    '{{64'h0001_0002_0003_0004, EXT_OK, 2'b11, 1'b0, 9'h1FC}, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 64'h0001_0002_0003_0004},
    // R4: s min == max
    '{{64'h0001_0002_0003_0004, EXT_SEQ, 2'b11, 1'b0, 9'h1FC}, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 64'h0},
    // R4: t min > max
    '{{64'h0001_0002_0003_0004, EXT_TREV, 2'b11, 1'b0, 9'h1FC}, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 64'h0},
    // R2: untagged block
    '{{64'h1111_2222_3333_4444, 64'h0}, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 64'h0},
    // R3 R10: illegal HDR negative does not set flag
    '{{64'hC000_C000_C000_C000, EXT_ONES, 2'b00, 1'b1, 9'h1FC}, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 64'h0},
    // R4: one field off all-ones
    '{{64'h0001_0002_0003_0004, EXT_NEAR, 2'b11, 1'b0, 9'h1FC}, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 64'h0}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic applyBlk(input logic [127:0] b, input logic h, input logic r, input logic clr);
    @(negedge clk);
    inBlock = b; hdrEn = h; sharedExpSel = r; clearNeg = clr; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0; clearNeg = 1'b0;
  endtask

  initial begin
    #(4ns * 200000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check({outValid, errFlag, isConst, negSeen} == 4'b0, "R1 reset flags",
          {60'h0, outValid, errFlag, isConst, negSeen}, 64'h0);
    check({colA, colB, colG, colR} == 64'h0, "R6 reset colour", {colA, colB, colG, colR}, 64'h0);

    // Table walk; each vector clears the sticky flag in its own cycle
    for (int i = 0; i < NV; i++) begin
      applyBlk(VECS[i].blk, VECS[i].hdr, VECS[i].rgb, 1'b1);
      check(outValid == 1'b1, $sformatf("R1 strobe vec%0d", i), {63'h0, outValid}, 64'h1);
      check(errFlag == VECS[i].eErr, $sformatf("R3 R4 R5 R9 error vec%0d", i), {63'h0, errFlag}, {63'h0, VECS[i].eErr});
      check(isConst == VECS[i].eConst, $sformatf("R2 tag vec%0d", i), {63'h0, isConst}, {63'h0, VECS[i].eConst});
      check({colA, colB, colG, colR} == VECS[i].eCol, $sformatf("R6 R7 R8 colour vec%0d", i),
            {colA, colB, colG, colR}, VECS[i].eCol);
      check(negSeen == VECS[i].eNeg, $sformatf("R10 neg vec%0d", i), {63'h0, negSeen}, {63'h0, VECS[i].eNeg});
    end

    // R1 R11: strobe drops, outputs hold while idle
    inBlock = '1; hdrEn = 1'b1; sharedExpSel = 1'b1;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R1 strobe low when idle", {63'h0, outValid}, 64'h0);
    check({colA, colB, colG, colR} == VECS[NV-1].eCol && errFlag == 1'b1, "R11 hold",
          {colA, colB, colG, colR}, VECS[NV-1].eCol);

    // R10 sticky behaviour
    applyBlk(VECS[3].blk, 1'b1, 1'b0, 1'b1);
    check(negSeen == 1'b1, "R10 set", {63'h0, negSeen}, 64'h1);
    applyBlk(VECS[6].blk, 1'b1, 1'b1, 1'b0);
    applyBlk(VECS[0].blk, 1'b0, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    check(negSeen == 1'b1, "R10 holds across clean blocks", {63'h0, negSeen}, 64'h1);
    clearNeg = 1'b1;
    @(negedge clk);
    clearNeg = 1'b0;
    check(negSeen == 1'b0, "R10 clear", {63'h0, negSeen}, 64'h0);
    applyBlk(VECS[3].blk, 1'b1, 1'b0, 1'b1);
    check(negSeen == 1'b1, "R10 set wins over clear", {63'h0, negSeen}, 64'h1);
    clearNeg = 1'b1;
    @(negedge clk);
    clearNeg = 1'b0;
    applyBlk(VECS[8].blk, 1'b1, 1'b1, 1'b0);
    check(negSeen == 1'b0, "R7 LDR never sets flag", {63'h0, negSeen}, 64'h0);

    // R11: back-to-back strobes then idle keep the second result
    @(negedge clk);
    inBlock = VECS[0].blk; hdrEn = 1'b0; sharedExpSel = 1'b0; inValid = 1'b1;
    @(negedge clk);
    inBlock = VECS[6].blk; hdrEn = 1'b1; sharedExpSel = 1'b1;
    @(negedge clk);
    inValid = 1'b0; inBlock = VECS[1].blk;
    repeat (2) @(negedge clk);
    check({colA, colB, colG, colR} == VECS[6].eCol, "R11 last result kept",
          {colA, colB, colG, colR}, VECS[6].eCol);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule